// File: doc/BRIEF.md
# System Control Register Block

A memory-mapped control and status register file for a small dual-core subsystem. It sits behind a 32-bit APB-style slave port with byte strobes. It holds the boot and reset related registers of the subsystem, and it turns some register writes into hardware events. A write to the software reset register asserts a one-cycle system reset request. Clearing a CPU hold bit gives a one-cycle release-and-reset pulse to that CPU. The two boot vector registers drive the initial vector addresses of the CPUs.

The build-time version parameter selects one of two variants. The extended variant adds a group of registers: security control, two clock dividers, clock force, the second boot vector, NMI enable and five power-domain sense words. In the base variant the offsets of that group act as unmapped, except the NMI enable offset, which reads as zero and ignores writes without an error. Every transfer completes in its access phase with no wait states. The component identification words sit at the top of the 4 KB window.

Top module: `sysctl_regs`

## Requirements
- R1: `pready_o` is always high. `prdata_o` and `pslverr_o` are zero whenever the port is not in an access phase (`psel_i` and `penable_i` both high). Read data is valid in the access phase itself.
- R2: After reset, the following values are read. Reset syndrome (0x100) reads 1. System power sense (0x200) reads 0x7F. The four SRAM sense words (0x20C, 0x210, 0x214, 0x218) read 0. Mask (0x104), retention (0x10C), security control (0x00C), dividers (0x010, 0x014), clock force (0x018), NMI enable (0x11C) and the debug state (0x000) read 0. The CPU hold register (0x118) and the boot vectors (0x110, 0x114) read their parameter values.
- R3: The plain read-write registers return the last word written to them.
- R4: A write replaces the whole 32-bit word. Byte lanes whose `pstrb_i` bit is low are written as zero. Reads return the full word.
- R5: The debug state at 0x000 is read-only, and a write to it gets a slave error. A write to 0x004 ORs the data into the state. A write to 0x008 clears each state bit written as 1. Offsets 0x004 and 0x008 read as zero.
- R6: A write to 0x108 with data bit 9 set raises `sys_reset_req_o` for exactly the cycle after the access. Every other bit of that register is ignored. The offset reads as zero.
- R7: In the hold register at 0x118, bit 0 belongs to CPU 0 and bit 1 to CPU 1. A write that takes a bit from 1 to 0 raises that CPU's bit of `cpu_release_o` for exactly the cycle after the access. Any other write gives no pulse.
- R8: `init_vtor0_o` and `init_vtor1_o` follow the boot vector registers at 0x110 and 0x114, changing in the cycle after the write.
- R9: Twelve identification words sit at 0xFD0 to 0xFFC in steps of 4. Their values are 0x04, 0, 0, 0, 0x54, 0xB8, 0x0B, 0, 0x0D, 0xF0, 0x05, 0xB1. A write to them is ignored and gets a slave error.
- R10: The extended variant is selected when `SYS_VERSION[31:28]` equals 2. In the base variant, 0x11C reads as zero and ignores writes, and gives no error.
- R11: In the base variant, the offsets 0x00C, 0x010, 0x014, 0x018, 0x114, 0x200 and 0x20C to 0x218 read as zero, ignore writes and give a slave error.
- R12: An access to any other offset reads as zero, changes no state and gives a slave error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase marker |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address in the 4 KB window; bits [1:0] ignored |
| pwdata_i | input | DATA_W | Write data |
| pstrb_i | input | DATA_W/8 | Write byte strobes |
| prdata_o | output | DATA_W | Read data |
| pready_o | output | 1 | Transfer complete |
| pslverr_o | output | 1 | Slave error response |
| sys_reset_req_o | output | 1 | One-cycle system reset request |
| cpu_release_o | output | 2 | Per-CPU one-cycle release-and-reset pulse |
| init_vtor0_o | output | DATA_W | Initial vector address for CPU 0 |
| init_vtor1_o | output | DATA_W | Initial vector address for CPU 1 |

## Verification
The bound checker watches several rules on every cycle. It checks that the response outputs stay quiet outside access phases. It checks that each reset request pulse has a bit-9 write to the reset offset one cycle earlier, and that it lasts one cycle. It checks that a release pulse appears only when a hold bit has just fallen. It checks that the debug state changes only after a write to the set or clear offsets. It also checks the error responses for unmapped offsets, for identification writes, and for the base variant's reserved NMI offset. The bench drives a base and an extended instance in parallel and compares them on every cycle against a behavioural model. Only these scenarios can show the stored values, the strobe padding, the OR and clear behaviour of the debug state, and the exact reset values from the parameters.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned WIN_AW     = 12;
  localparam int unsigned N_CPU      = 2;
  localparam int unsigned SW_RST_BIT = 9;

  localparam logic [11:0] OFF_DBG_STATE = 12'h000;
  localparam logic [11:0] OFF_DBG_SET   = 12'h004;
  localparam logic [11:0] OFF_DBG_CLR   = 12'h008;
  localparam logic [11:0] OFF_SEC_CTRL  = 12'h00C;
  localparam logic [11:0] OFF_FCLK_DIV  = 12'h010;
  localparam logic [11:0] OFF_SCLK_DIV  = 12'h014;
  localparam logic [11:0] OFF_CLK_FORCE = 12'h018;
  localparam logic [11:0] OFF_RST_SYN   = 12'h100;
  localparam logic [11:0] OFF_RST_MASK  = 12'h104;
  localparam logic [11:0] OFF_SW_RST    = 12'h108;
  localparam logic [11:0] OFF_RETAIN    = 12'h10C;
  localparam logic [11:0] OFF_VTOR0     = 12'h110;
  localparam logic [11:0] OFF_VTOR1     = 12'h114;
  localparam logic [11:0] OFF_CPU_HOLD  = 12'h118;
  localparam logic [11:0] OFF_NMI       = 12'h11C;
  localparam logic [11:0] OFF_PD_SYS    = 12'h200;
  localparam logic [11:0] OFF_PD_SRAM0  = 12'h20C;
  localparam logic [11:0] OFF_ID_BASE   = 12'hFD0;

  typedef enum logic [4:0] {
    REG_NONE, REG_DBG_STATE, REG_DBG_SET, REG_DBG_CLR, REG_SEC_CTRL,
    REG_FCLK_DIV, REG_SCLK_DIV, REG_CLK_FORCE, REG_RST_SYN, REG_RST_MASK,
    REG_SW_RST, REG_RETAIN, REG_VTOR0, REG_VTOR1, REG_CPU_HOLD, REG_NMI,
    REG_PD_SYS, REG_PD_SRAM, REG_ID
  } reg_id_e;

  typedef struct packed {
    reg_id_e    id;
    logic [3:0] idx;
    logic       ext_only;
    logic       read_only;
  } dec_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h54;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h0B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter bit          IS_EXT = 1'b1,
  parameter int unsigned N_SRAM = 4
) (
  input  logic [11:0] off_i,
  input  logic        wr_i,
  output reg_id_e     sel_o,
  output logic [3:0]  idx_o,
  output logic        err_o
);
  localparam logic [11:0] SRAM_END = 12'(int'(OFF_PD_SRAM0) + 4 * N_SRAM);

  dec_t raw;

  always_comb begin
    raw = '{id: REG_NONE, idx: 4'd0, ext_only: 1'b0, read_only: 1'b0};
    case (off_i)
      OFF_DBG_STATE: begin raw.id = REG_DBG_STATE; raw.read_only = 1'b1; end
      OFF_DBG_SET:   raw.id = REG_DBG_SET;
      OFF_DBG_CLR:   raw.id = REG_DBG_CLR;
      OFF_SEC_CTRL:  begin raw.id = REG_SEC_CTRL;  raw.ext_only = 1'b1; end
      OFF_FCLK_DIV:  begin raw.id = REG_FCLK_DIV;  raw.ext_only = 1'b1; end
      OFF_SCLK_DIV:  begin raw.id = REG_SCLK_DIV;  raw.ext_only = 1'b1; end
      OFF_CLK_FORCE: begin raw.id = REG_CLK_FORCE; raw.ext_only = 1'b1; end
      OFF_RST_SYN:   raw.id = REG_RST_SYN;
      OFF_RST_MASK:  raw.id = REG_RST_MASK;
      OFF_SW_RST:    raw.id = REG_SW_RST;
      OFF_RETAIN:    raw.id = REG_RETAIN;
      OFF_VTOR0:     raw.id = REG_VTOR0;
      OFF_VTOR1:     begin raw.id = REG_VTOR1;  raw.ext_only = 1'b1; end
      OFF_CPU_HOLD:  raw.id = REG_CPU_HOLD;
      OFF_NMI:       raw.id = REG_NMI;
      OFF_PD_SYS:    begin raw.id = REG_PD_SYS; raw.ext_only = 1'b1; end
      default:       raw.id = REG_NONE;
    endcase
    if (off_i >= OFF_PD_SRAM0 && off_i < SRAM_END) begin
      raw.id       = REG_PD_SRAM;
      raw.idx      = 4'((off_i - OFF_PD_SRAM0) >> 2);
      raw.ext_only = 1'b1;
    end
    if (off_i >= OFF_ID_BASE) begin
      raw.id        = REG_ID;
      raw.idx       = 4'((off_i - OFF_ID_BASE) >> 2);
      raw.read_only = 1'b1;
    end
  end

  // variant gating: extended-only offsets vanish, NMI slot becomes silent zero
  always_comb begin
    sel_o = raw.id;
    idx_o = raw.idx;
    err_o = 1'b0;
    if (raw.id == REG_NONE) begin
      err_o = 1'b1;
    end else if (raw.ext_only && !IS_EXT) begin
      sel_o = REG_NONE;
      err_o = 1'b1;
    end else if (raw.id == REG_NMI && !IS_EXT) begin
      sel_o = REG_NONE;
    end else if (raw.read_only && wr_i) begin
      err_o = 1'b1;
    end
  end
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_o <= '0;
    else if (set_en_i) state_o <= state_o | data_i;
    else if (clr_en_i) state_o <= state_o & ~data_i;
  end
endmodule

// File: rtl/sysctl_hold_release.sv
module sysctl_hold_release #(
  parameter int unsigned   N       = 2,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] hold_o,
  output logic [N-1:0] release_o
);
  for (genvar i = 0; i < N; i++) begin : g_cpu
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_o[i]    <= RST_VAL[i];
        release_o[i] <= 1'b0;
      end else begin
        // pulse only on a 1 -> 0 transition of the hold bit
        release_o[i] <= wr_en_i & hold_o[i] & ~data_i[i];
        if (wr_en_i) hold_o[i] <= data_i[i];
      end
    end
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned       DATA_W       = 32,
  parameter int unsigned       N_SRAM       = 4,
  parameter logic [31:0]       SYS_VERSION  = 32'h2000_0000,
  parameter logic [N_CPU-1:0]  CPU_HOLD_RST = '0,
  parameter logic [DATA_W-1:0] VTOR0_RST    = DATA_W'(32'h1000_0000),
  parameter logic [DATA_W-1:0] VTOR1_RST    = DATA_W'(32'h1000_0000)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [WIN_AW-1:0]   paddr_i,
  input  logic [DATA_W-1:0]   pwdata_i,
  input  logic [DATA_W/8-1:0] pstrb_i,
  output logic [DATA_W-1:0]   prdata_o,
  output logic                pready_o,
  output logic                pslverr_o,
  output logic                sys_reset_req_o,
  output logic [N_CPU-1:0]    cpu_release_o,
  output logic [DATA_W-1:0]   init_vtor0_o,
  output logic [DATA_W-1:0]   init_vtor1_o
);
  localparam bit          IS_EXT   = (SYS_VERSION[31:28] == 4'd2);
  localparam int unsigned STRB_W   = DATA_W / 8;
  localparam logic [DATA_W-1:0] PD_SYS_RST = DATA_W'(32'h7F);

  logic [WIN_AW-1:0] off;
  logic [DATA_W-1:0] wmask, wdata, rdata;
  logic              acc, wr_en, dec_err;
  reg_id_e           sel;
  logic [3:0]        idx;

  logic [DATA_W-1:0] dbg_q, rst_syn_q, rst_mask_q, retain_q, vtor0_q;
  logic [DATA_W-1:0] sec_ctrl_q, fclk_div_q, sclk_div_q, clk_force_q;
  logic [DATA_W-1:0] vtor1_q, nmi_q, pd_sys_q;
  logic [DATA_W-1:0] pd_sram_q [N_SRAM];
  logic [N_CPU-1:0]  cpu_hold_q;
  logic              swrst_q;

  assign off   = paddr_i & ~WIN_AW'(3);
  assign acc   = psel_i & penable_i;
  assign wr_en = acc & pwrite_i & ~dec_err;

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign wmask[8*b +: 8] = {8{pstrb_i[b]}};
  end
  assign wdata = pwdata_i & wmask;

  sysctl_decode #(.IS_EXT(IS_EXT), .N_SRAM(N_SRAM)) u_decode (
    .off_i (off),
    .wr_i  (pwrite_i),
    .sel_o (sel),
    .idx_o (idx),
    .err_o (dec_err)
  );

  sysctl_setclr #(.W(DATA_W)) u_dbg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (wr_en && sel == REG_DBG_SET),
    .clr_en_i (wr_en && sel == REG_DBG_CLR),
    .data_i   (wdata),
    .state_o  (dbg_q)
  );

  sysctl_hold_release #(.N(N_CPU), .RST_VAL(CPU_HOLD_RST)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en && sel == REG_CPU_HOLD),
    .data_i    (wdata[N_CPU-1:0]),
    .hold_o    (cpu_hold_q),
    .release_o (cpu_release_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_syn_q  <= DATA_W'(1);
      rst_mask_q <= '0;
      retain_q   <= '0;
      vtor0_q    <= VTOR0_RST;
      swrst_q    <= 1'b0;
    end else begin
      swrst_q <= wr_en && sel == REG_SW_RST && wdata[SW_RST_BIT];
      if (wr_en) begin
        case (sel)
          REG_RST_SYN:  rst_syn_q  <= wdata;
          REG_RST_MASK: rst_mask_q <= wdata;
          REG_RETAIN:   retain_q   <= wdata;
          REG_VTOR0:    vtor0_q    <= wdata;
          default: ;
        endcase
      end
    end
  end

  if (IS_EXT) begin : g_ext
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sec_ctrl_q  <= '0;
        fclk_div_q  <= '0;
        sclk_div_q  <= '0;
        clk_force_q <= '0;
        vtor1_q     <= VTOR1_RST;
        nmi_q       <= '0;
        pd_sys_q    <= PD_SYS_RST;
        for (int k = 0; k < N_SRAM; k++) pd_sram_q[k] <= '0;
      end else if (wr_en) begin
        case (sel)
          REG_SEC_CTRL:  sec_ctrl_q  <= wdata;
          REG_FCLK_DIV:  fclk_div_q  <= wdata;
          REG_SCLK_DIV:  sclk_div_q  <= wdata;
          REG_CLK_FORCE: clk_force_q <= wdata;
          REG_VTOR1:     vtor1_q     <= wdata;
          REG_NMI:       nmi_q       <= wdata;
          REG_PD_SYS:    pd_sys_q    <= wdata;
          REG_PD_SRAM:
            for (int k = 0; k < N_SRAM; k++)
              if (idx == 4'(k)) pd_sram_q[k] <= wdata;
          default: ;
        endcase
      end
    end
  end else begin : g_base
    assign sec_ctrl_q  = '0;
    assign fclk_div_q  = '0;
    assign sclk_div_q  = '0;
    assign clk_force_q = '0;
    assign vtor1_q     = VTOR1_RST;
    assign nmi_q       = '0;
    assign pd_sys_q    = '0;
    for (genvar k = 0; k < N_SRAM; k++) begin : g_sram
      assign pd_sram_q[k] = '0;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      REG_DBG_STATE: rdata = dbg_q;
      REG_SEC_CTRL:  rdata = sec_ctrl_q;
      REG_FCLK_DIV:  rdata = fclk_div_q;
      REG_SCLK_DIV:  rdata = sclk_div_q;
      REG_CLK_FORCE: rdata = clk_force_q;
      REG_RST_SYN:   rdata = rst_syn_q;
      REG_RST_MASK:  rdata = rst_mask_q;
      REG_RETAIN:    rdata = retain_q;
      REG_VTOR0:     rdata = vtor0_q;
      REG_VTOR1:     rdata = vtor1_q;
      REG_CPU_HOLD:  rdata = DATA_W'(cpu_hold_q);
      REG_NMI:       rdata = nmi_q;
      REG_PD_SYS:    rdata = pd_sys_q;
      REG_PD_SRAM:
        for (int k = 0; k < N_SRAM; k++)
          if (idx == 4'(k)) rdata = pd_sram_q[k];
      REG_ID:        rdata = DATA_W'(id_byte(idx));
      default:       rdata = '0;
    endcase
  end

  assign prdata_o        = (acc && !pwrite_i) ? rdata : '0;
  assign pslverr_o       = acc & dec_err;
  assign pready_o        = 1'b1;
  assign sys_reset_req_o = swrst_q;
  assign init_vtor0_o    = vtor0_q;
  assign init_vtor1_o    = vtor1_q;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter bit          IS_EXT = 1'b1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                psel_i,
  input logic                penable_i,
  input logic                pwrite_i,
  input logic [WIN_AW-1:0]   paddr_i,
  input logic [DATA_W-1:0]   pwdata_i,
  input logic [DATA_W/8-1:0] pstrb_i,
  input logic [DATA_W-1:0]   prdata_o,
  input logic                pslverr_o,
  input logic                sys_reset_req_o,
  input logic [N_CPU-1:0]    cpu_release_o,
  input logic [N_CPU-1:0]    cpu_hold_q,
  input logic [DATA_W-1:0]   dbg_q
);
  logic [WIN_AW-1:0] off;
  logic              acc;
  assign off = paddr_i & ~WIN_AW'(3);
  assign acc = psel_i & penable_i;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |-> (!pslverr_o && prdata_o == '0));

  assert_rst_req_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_o |-> $past(acc && pwrite_i && off == OFF_SW_RST &&
                              pwdata_i[SW_RST_BIT] && pstrb_i[SW_RST_BIT/8]));

  assert_rst_req_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_o |=> !sys_reset_req_o);

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_chk
    assert_release_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_release_o[i] |-> $fell(cpu_hold_q[i]));
    assert_release_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_release_o[i] |=> !cpu_release_o[i]);
  end

  assert_dbg_only_by_port_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && pwrite_i && (off == OFF_DBG_SET || off == OFF_DBG_CLR)) |=> $stable(dbg_q));

  assert_id_write_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && pwrite_i && off >= OFF_ID_BASE) |-> pslverr_o);

  assert_nmi_base_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!IS_EXT && acc && off == OFF_NMI) |-> (!pslverr_o && prdata_o == '0));

  assert_hole_err_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && off >= 12'h300 && off < OFF_ID_BASE) |-> (pslverr_o && prdata_o == '0));
endmodule

bind sysctl_regs sysctl_regs_chk #(.DATA_W(DATA_W), .IS_EXT(IS_EXT)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .psel_i          (psel_i),
  .penable_i       (penable_i),
  .pwrite_i        (pwrite_i),
  .paddr_i         (paddr_i),
  .pwdata_i        (pwdata_i),
  .pstrb_i         (pstrb_i),
  .prdata_o        (prdata_o),
  .pslverr_o       (pslverr_o),
  .sys_reset_req_o (sys_reset_req_o),
  .cpu_release_o   (cpu_release_o),
  .cpu_hold_q      (cpu_hold_q),
  .dbg_q           (dbg_q)
);

// File: tb/sysctl_regs_tb_top.sv
module sysctl_regs_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] VER_BASE   = 32'h1000_0003;
  localparam logic [31:0] VER_EXT    = 32'h2000_0001;
  localparam logic [1:0]  HOLD_RST   = 2'b11;
  localparam logic [31:0] V0_RST     = 32'h1000_0000;
  localparam logic [31:0] V1_RST     = 32'h1000_4000;

  localparam int K_NONE = 0, K_RW = 1, K_DBG = 2, K_SET = 3, K_CLR = 4;
  localparam int K_SWRST = 5, K_HOLD = 6, K_NMI = 7, K_ID = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;

  logic [31:0] prdata [2];
  logic        pready [2];
  logic        pslverr [2];
  logic        srst [2];
  logic [1:0]  rel [2];
  logic [31:0] vt0 [2];
  logic [31:0] vt1 [2];

  logic [31:0] mreg [int];
  logic        exp_srst [2];
  logic [1:0]  exp_rel [2];
  logic [31:0] exp_v0 [2];
  logic [31:0] exp_v1 [2];

  int  n_checks = 0, n_err = 0;
  bit  done = 1'b0;
  int  id_vals [12] = '{'h04, 0, 0, 0, 'h54, 'hB8, 'h0B, 0, 'h0D, 'hF0, 'h05, 'hB1};
  int  reg_offs [16] = '{'h000, 'h00C, 'h010, 'h014, 'h018, 'h100, 'h104, 'h10C,
                         'h110, 'h114, 'h118, 'h11C, 'h200, 'h20C, 'h214, 'h218};

  always #(CLK_PERIOD / 2) clk = ~clk;

  sysctl_regs #(.SYS_VERSION(VER_BASE), .CPU_HOLD_RST(HOLD_RST),
                .VTOR0_RST(V0_RST), .VTOR1_RST(V1_RST)) base_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .pstrb_i(pstrb),
    .prdata_o(prdata[0]), .pready_o(pready[0]), .pslverr_o(pslverr[0]),
    .sys_reset_req_o(srst[0]), .cpu_release_o(rel[0]),
    .init_vtor0_o(vt0[0]), .init_vtor1_o(vt1[0]));

  sysctl_regs #(.SYS_VERSION(VER_EXT), .CPU_HOLD_RST(HOLD_RST),
                .VTOR0_RST(V0_RST), .VTOR1_RST(V1_RST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .pstrb_i(pstrb),
    .prdata_o(prdata[1]), .pready_o(pready[1]), .pslverr_o(pslverr[1]),
    .sys_reset_req_o(srst[1]), .cpu_release_o(rel[1]),
    .init_vtor0_o(vt0[1]), .init_vtor1_o(vt1[1]));

  task automatic check(string req, int v, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s variant=%0d act=%h exp=%h t=%0t", req, v, act, expv, $time);
    end
  endtask

  function automatic int kind_of(int v, int off);
    case (off)
      'h000: return K_DBG;
      'h004: return K_SET;
      'h008: return K_CLR;
      'h00C, 'h010, 'h014, 'h018, 'h114, 'h200,
      'h20C, 'h210, 'h214, 'h218: return (v == 1) ? K_RW : K_NONE;
      'h100, 'h104, 'h10C, 'h110: return K_RW;
      'h108: return K_SWRST;
      'h118: return K_HOLD;
      'h11C: return K_NMI;
      default: return (off >= 'hFD0 && off <= 'hFFC) ? K_ID : K_NONE;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(logic [3:0] s);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (s[b]) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic model_reset();
    for (int v = 0; v < 2; v++) begin
      foreach (reg_offs[i]) mreg[v*4096 + reg_offs[i]] = '0;
      mreg[v*4096 + 'h210] = '0;
      mreg[v*4096 + 'h100] = 32'h1;
      mreg[v*4096 + 'h200] = 32'h7F;
      mreg[v*4096 + 'h110] = V0_RST;
      mreg[v*4096 + 'h114] = V1_RST;
      mreg[v*4096 + 'h118] = {30'b0, HOLD_RST};
      exp_srst[v] = 1'b0;
      exp_rel[v]  = 2'b00;
      exp_v0[v]   = V0_RST;
      exp_v1[v]   = V1_RST;
    end
  endtask

  task automatic model_access(int v, int off, bit wr, logic [31:0] wd,
                              output logic [31:0] rd, output bit err,
                              output bit sr, output logic [1:0] rl);
    int key = v*4096 + off;
    rd = '0; err = 1'b0; sr = 1'b0; rl = 2'b00;
    case (kind_of(v, off))
      K_RW:    if (wr) mreg[key] = wd; else rd = mreg[key];
      K_DBG:   if (wr) err = 1'b1; else rd = mreg[v*4096];
      K_SET:   if (wr) mreg[v*4096] = mreg[v*4096] | wd;
      K_CLR:   if (wr) mreg[v*4096] = mreg[v*4096] & ~wd;
      K_SWRST: if (wr) sr = wd[9];
      K_HOLD:  if (wr) begin
                 rl = mreg[key][1:0] & ~wd[1:0];
                 mreg[key] = {30'b0, wd[1:0]};
               end else rd = mreg[key];
      K_NMI:   if (v == 1) begin if (wr) mreg[key] = wd; else rd = mreg[key]; end
      K_ID:    if (wr) err = 1'b1; else rd = 32'(id_vals[(off - 'hFD0) / 4]);
      default: err = 1'b1;
    endcase
  endtask

  task automatic bus(bit wr, int off, logic [31:0] wd, logic [3:0] strb, string req);
    logic [31:0] rd;
    bit          err;
    bit          sr [2];
    logic [1:0]  rl [2];
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = off[11:0];
    pwdata = wd; pstrb = wr ? strb : 4'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    for (int v = 0; v < 2; v++) begin
      model_access(v, off, wr, wd & lane_mask(wr ? strb : 4'b0), rd, err, sr[v], rl[v]);
      check(req, v, prdata[v], rd);
      check(req, v, 32'(pslverr[v]), 32'(err));
    end
    @(posedge clk);
    #1;
    for (int v = 0; v < 2; v++) begin
      exp_srst[v] = sr[v];
      exp_rel[v]  = rl[v];
      exp_v0[v]   = mreg[v*4096 + 'h110];
      exp_v1[v]   = mreg[v*4096 + 'h114];
    end
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    @(posedge clk);
    #1;
    for (int v = 0; v < 2; v++) begin
      exp_srst[v] = 1'b0;
      exp_rel[v]  = 2'b00;
    end
  endtask

  // per-cycle comparison of event outputs and idle response
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #2;
      for (int v = 0; v < 2; v++) begin
        check("R6", v, 32'(srst[v]), 32'(exp_srst[v]));
        check("R7", v, 32'(rel[v]), 32'(exp_rel[v]));
        check("R8", v, vt0[v], exp_v0[v]);
        check("R8", v, vt1[v], exp_v1[v]);
        check("R1", v, 32'(pready[v]), 32'h1);
        if (!(psel && penable)) begin
          check("R1", v, prdata[v], 32'h0);
          check("R1", v, 32'(pslverr[v]), 32'h0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: reset values
    foreach (reg_offs[i]) bus(1'b0, reg_offs[i], '0, '0, "R2");
    bus(1'b0, 'h210, '0, '0, "R2");

    // R3: plain read-write storage
    foreach (reg_offs[i]) bus(1'b1, reg_offs[i], 32'hA500_0000 ^ (reg_offs[i] * 32'h0101_0101), 4'hF, "R3");
    foreach (reg_offs[i]) bus(1'b0, reg_offs[i], '0, '0, "R3");

    // R4: partial strobes zero-pad the other lanes
    bus(1'b1, 'h10C, 32'hAABB_CCDD, 4'b0010, "R4");
    bus(1'b0, 'h10C, '0, '0, "R4");
    bus(1'b1, 'h104, 32'h1122_3344, 4'b1001, "R4");
    bus(1'b0, 'h104, '0, '0, "R4");

    // R5: debug set / clear
    bus(1'b1, 'h004, 32'h0000_0F0F, 4'hF, "R5");
    bus(1'b1, 'h004, 32'h3000_0000, 4'hF, "R5");
    bus(1'b0, 'h000, '0, '0, "R5");
    bus(1'b1, 'h008, 32'h1000_0103, 4'hF, "R5");
    bus(1'b0, 'h000, '0, '0, "R5");
    bus(1'b1, 'h000, 32'hFFFF_FFFF, 4'hF, "R5");
    bus(1'b0, 'h000, '0, '0, "R5");
    bus(1'b0, 'h004, '0, '0, "R5");
    bus(1'b0, 'h008, '0, '0, "R5");

    // R6: software reset request
    bus(1'b1, 'h108, 32'h0000_0200, 4'hF, "R6");
    bus(1'b1, 'h108, 32'hFFFF_FDFF, 4'hF, "R6");
    bus(1'b1, 'h108, 32'h0000_0200, 4'b0001, "R6");
    bus(1'b0, 'h108, '0, '0, "R6");

    // R7: CPU hold release edges
    bus(1'b1, 'h118, 32'h3, 4'hF, "R7");
    bus(1'b1, 'h118, 32'h2, 4'hF, "R7");
    bus(1'b1, 'h118, 32'h3, 4'hF, "R7");
    bus(1'b1, 'h118, 32'h3, 4'hF, "R7");
    bus(1'b1, 'h118, 32'h0, 4'hF, "R7");
    bus(1'b1, 'h118, 32'h0, 4'hF, "R7");
    bus(1'b1, 'h118, 32'h1, 4'hF, "R7");
    bus(1'b1, 'h118, 32'h2, 4'hF, "R7");
    bus(1'b0, 'h118, '0, '0, "R7");

    // R8: boot vectors to outputs
    bus(1'b1, 'h110, 32'h2000_0100, 4'hF, "R8");
    bus(1'b1, 'h114, 32'h2000_8000, 4'hF, "R8");

    // R9: identification words
    for (int k = 0; k < 12; k++) bus(1'b0, 'hFD0 + 4*k, '0, '0, "R9");
    bus(1'b1, 'hFD0, 32'hFFFF_FFFF, 4'hF, "R9");
    bus(1'b1, 'hFF4, 32'h0, 4'hF, "R9");
    bus(1'b0, 'hFD0, '0, '0, "R9");

    // R10: NMI slot per variant
    bus(1'b1, 'h11C, 32'h0000_0001, 4'hF, "R10");
    bus(1'b0, 'h11C, '0, '0, "R10");

    // R11: extended-only group in the base variant
    bus(1'b1, 'h014, 32'h0000_0007, 4'hF, "R11");
    bus(1'b0, 'h014, '0, '0, "R11");
    bus(1'b1, 'h218, 32'h0000_00FF, 4'hF, "R11");
    bus(1'b0, 'h218, '0, '0, "R11");

    // R12: holes in the map
    bus(1'b0, 'h800, '0, '0, "R12");
    bus(1'b1, 'h800, 32'h1234_5678, 4'hF, "R12");
    bus(1'b0, 'h204, '0, '0, "R12");
    bus(1'b0, 'h120, '0, '0, "R12");
    bus(1'b1, 'h0FC, 32'hDEAD_BEEF, 4'hF, "R12");
    bus(1'b0, 'hFCC, '0, '0, "R12");

    // mixed traffic over the whole map
    for (int n = 0; n < 300; n++) begin
      int          sel = int'($urandom_range(0, 19));
      int          off;
      logic [31:0] d = $urandom;
      if (sel < 16) off = reg_offs[sel];
      else if (sel == 16) off = 'h004;
      else if (sel == 17) off = 'h008;
      else if (sel == 18) off = 'h108;
      else off = 'hFD0 + 4 * int'($urandom_range(0, 11));
      bus(1'($urandom_range(0, 1)), off, d, 4'($urandom_range(0, 15)), "R3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule